// File: doc/BRIEF.md
# Free-running counter with compare interrupt

This block is a memory-mapped timer. A 64-bit count starts at zero and advances by one every third cycle of the input clock; it cannot be written. Software reads it as two 32-bit words and copes with a carry between the two reads by reading the high word, then the low word, then the high word again, and retrying if the two high values differ.

A compare frame sits at a large fixed offset above the count words. It holds a 52-bit compare value, kept as a full low word and a 20-bit high word, and a control word with an enable bit, an interrupt mask bit and a read-only status bit. While the frame is enabled and the count has reached the compare value, the status bit sets and stays set. The interrupt output is high when the status is set and the mask is clear. The only way to clear the status is to write the enable bit as zero. Software normally clears the enable, reads the count, writes the compare words and then sets the enable again.

The register port is a plain single-cycle 32-bit port: a write enable, an address and write data, with read data driven combinationally from the address.

Top module: `freerun_cmp_timer`

## Requirements
- R1: After reset the count is zero. It advances by exactly one on every third rising clock edge, so after N edges out of reset it reads N/3, rounded down.
- R2: Count bits [31:0] read at offset 0x8 and bits [63:32] at offset 0xC. Writes to these offsets have no effect on the count.
- R3: The compare low word is at 0x10020 and is a full 32-bit read/write word. The compare high word is at 0x10024 and stores only write-data bits [19:0]; bits [31:20] read as zero and take no part in the comparison.
- R4: The control word is at 0x1002C: bit 0 is the enable, bit 1 is the interrupt mask, bit 2 is the status (read-only, writes to it are ignored), and bits [31:3] read as zero.
- R5: On each clock edge where the enable (as written on that edge, or as held) is 1 and count bits [51:0] are greater than or equal to the compare value, the status sets. It stays set while the enable stays 1, even when the compare value is later raised.
- R6: The interrupt output is high exactly when the status is 1 and the mask is 0. The mask does not stop the status from setting.
- R7: A control write with bit 0 at zero clears the status and drops the interrupt on the same edge that clears the enable.
- R8: A write to a compare word takes effect for matching from the next edge onward. The edge that performs the write still compares against the old value.
- R9: After reset the compare low word reads 0xFFFFFFFF, the compare high word reads 0x000FFFFF, and the control word reads 0. Reads of any offset other than the five listed return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; the count advances on one edge in three |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Write strobe for the register port, one edge per write |
| reg_addr_i | input | 17 | Byte offset of the register addressed for read or write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, valid in the same cycle |
| irq_o | output | 1 | Compare interrupt, level-sensitive, active high |

## Verification
The hard case is the exact edge where the count first reaches the compare value. The count moves only one step in three cycles, so the status can be early or late by a whole count step and still look right when sampled once. The stimulus clears the enable, loads a compare value a few steps ahead of the live count, re-arms the frame and then checks the status every cycle against a count that the bench works out from its own edge tally. Random offsets, masks and a compare value already behind the count cover this edge in many alignments with the divide-by-three phase.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // Byte offsets of the register port; decode depends on these values
  localparam logic [31:0] OFF_CNT_LO  = 32'h0000_0008;
  localparam logic [31:0] OFF_CNT_HI  = 32'h0000_000C;
  localparam logic [31:0] FRAME_BASE  = 32'h0001_0000;
  localparam logic [31:0] OFF_CMP_LO  = FRAME_BASE + 32'h20;
  localparam logic [31:0] OFF_CMP_HI  = FRAME_BASE + 32'h24;
  localparam logic [31:0] OFF_CTRL    = FRAME_BASE + 32'h2C;

  // Control word bit positions
  localparam int unsigned CTRL_EN_BIT    = 0;
  localparam int unsigned CTRL_MASK_BIT  = 1;
  localparam int unsigned CTRL_STAT_BIT  = 2;

  typedef struct packed {
    logic cnt_lo;
    logic cnt_hi;
    logic cmp_lo;
    logic cmp_hi;
    logic ctrl;
  } reg_sel_t;

  // Decode a zero-extended byte offset into one-hot selects
  function automatic reg_sel_t decode_offset(logic [31:0] off);
    reg_sel_t s;
    s.cnt_lo = (off == OFF_CNT_LO);
    s.cnt_hi = (off == OFF_CNT_HI);
    s.cmp_lo = (off == OFF_CMP_LO);
    s.cmp_hi = (off == OFF_CMP_HI);
    s.ctrl   = (off == OFF_CTRL);
    return s;
  endfunction

  // True when the low `width` bits of cnt are at or past cmp
  function automatic logic reached(logic [63:0] cnt, logic [63:0] cmp,
                                   int unsigned width);
    logic [63:0] keep;
    if (width >= 64) keep = '1;
    else             keep = (64'd1 << width) - 64'd1;
    return (cnt & keep) >= (cmp & keep);
  endfunction

  // Next value of the prescaler phase for a divide ratio
  function automatic int unsigned next_phase(int unsigned ph, int unsigned div);
    return (ph + 1 >= div) ? 0 : ph + 1;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  import timer_pkg::*;

  localparam int unsigned PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase_q;

  generate
    if (DIV <= 1) begin : g_passthru
      assign tick_o = 1'b1;
      always_ff @(posedge clk_i) phase_q <= '0;
    end else begin : g_div
      always_ff @(posedge clk_i) begin
        if (!rst_ni) phase_q <= '0;
        else         phase_q <= PH_W'(next_phase(32'(phase_q), DIV));
      end
      assign tick_o = (phase_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     count_q <= '0;
    else if (tick_i) count_q <= count_q + CNT_W'(1);
  end

  assign count_o = count_q;

endmodule

// File: rtl/tmr_cmp_frame.sv
module tmr_cmp_frame #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned CMP_W = 52
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_lo_i,
  input  logic             sel_hi_i,
  input  logic             sel_ctrl_i,
  input  logic [31:0]      wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CMP_W-1:0] cmp_o,
  output logic             en_o,
  output logic             imask_o,
  output logic             istat_o,
  output logic             match_o,
  output logic             ctrl_wr_o
);
  import timer_pkg::*;

  localparam int unsigned HI_W = CMP_W - 32;

  logic [31:0]     cmp_lo_q;
  logic [HI_W-1:0] cmp_hi_q;
  logic            en_q, imask_q, istat_q;
  logic            en_d;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cmp_lo_q <= '1;
      cmp_hi_q <= '1;
    end else if (we_i) begin
      if (sel_lo_i) cmp_lo_q <= wdata_i;
      if (sel_hi_i) cmp_hi_q <= wdata_i[HI_W-1:0];
    end
  end

  assign cmp_o     = {cmp_hi_q, cmp_lo_q};
  assign ctrl_wr_o = we_i & sel_ctrl_i;
  assign match_o   = reached(64'(count_i), 64'(cmp_o), CMP_W);
  assign en_d      = ctrl_wr_o ? wdata_i[CTRL_EN_BIT] : en_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      imask_q <= 1'b0;
      istat_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      if (ctrl_wr_o) imask_q <= wdata_i[CTRL_MASK_BIT];
      istat_q <= en_d & (istat_q | match_o);
    end
  end

  assign en_o    = en_q;
  assign imask_o = imask_q;
  assign istat_o = istat_q;

endmodule

// File: rtl/freerun_cmp_timer.sv
module freerun_cmp_timer #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DIV    = 3,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned CMP_W  = 52
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  import timer_pkg::*;

  localparam int unsigned HI_W = CMP_W - 32;

  reg_sel_t         sel_w;
  logic             tick_w;
  logic [CNT_W-1:0] count_w;
  logic [CMP_W-1:0] cmp_w;
  logic             en_w, imask_w, istat_w, match_w, ctrl_wr_w;
  logic [63:0]      count64_w;

  assign sel_w = decode_offset(32'(reg_addr_i));

  tmr_prescaler #(.DIV(DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick_w)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_w),
    .count_o (count_w)
  );

  tmr_cmp_frame #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .sel_lo_i   (sel_w.cmp_lo),
    .sel_hi_i   (sel_w.cmp_hi),
    .sel_ctrl_i (sel_w.ctrl),
    .wdata_i    (reg_wdata_i),
    .count_i    (count_w),
    .cmp_o      (cmp_w),
    .en_o       (en_w),
    .imask_o    (imask_w),
    .istat_o    (istat_w),
    .match_o    (match_w),
    .ctrl_wr_o  (ctrl_wr_w)
  );

  assign count64_w = 64'(count_w);

  always_comb begin
    reg_rdata_o = '0;
    unique case (1'b1)
      sel_w.cnt_lo: reg_rdata_o = count64_w[31:0];
      sel_w.cnt_hi: reg_rdata_o = count64_w[63:32];
      sel_w.cmp_lo: reg_rdata_o = cmp_w[31:0];
      sel_w.cmp_hi: reg_rdata_o = 32'(cmp_w[CMP_W-1:32]);
      sel_w.ctrl: begin
        reg_rdata_o[CTRL_EN_BIT]   = en_w;
        reg_rdata_o[CTRL_MASK_BIT] = imask_w;
        reg_rdata_o[CTRL_STAT_BIT] = istat_w;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = istat_w & ~imask_w;

endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned CNT_W  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_w,
  input logic [CNT_W-1:0]  count_w,
  input logic              en_w,
  input logic              imask_w,
  input logic              istat_w,
  input logic              match_w,
  input logic              ctrl_wr_w,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [31:0]       reg_rdata_o,
  input logic              irq_o
);
  // R1: a prescaler tick moves the count by one
  a_r1_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_w |=> count_w == $past(count_w) + CNT_W'(1));

  // R1: without a tick the count holds
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_w |=> $stable(count_w));

  // R3: upper bits of the compare high word read zero
  a_r3_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(reg_addr_i) == 32'h0001_0024) |-> reg_rdata_o[31:20] == 12'h0);

  // R5: an armed frame that sees a match holds status next cycle
  a_r5_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_w && match_w && !ctrl_wr_w) |=> istat_w);

  // R5: status is sticky while the enable is kept
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (istat_w && !ctrl_wr_w) |=> istat_w);

  // R6: a set mask keeps the interrupt low
  a_r6_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imask_w |-> !irq_o);

  // R7: writing enable low clears status and interrupt
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_w && !reg_wdata_i[0]) |=> (!istat_w && !irq_o));

  // R4: status never set while disabled
  a_r4_stat_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    istat_w |-> en_w);

  // R2: the write strobe alone never moves the count off its step
  a_r2_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !tick_w) |=> $stable(count_w));
endmodule

bind freerun_cmp_timer timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_w      (tick_w),
  .count_w     (count_w),
  .en_w        (en_w),
  .imask_w     (imask_w),
  .istat_w     (istat_w),
  .match_w     (match_w),
  .ctrl_wr_w   (ctrl_wr_w),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o)
);

// File: tb/freerun_cmp_timer_tb.sv
`timescale 1ns/100ps
module freerun_cmp_timer_tb_top;

  localparam logic [16:0] A_CLO  = 17'h00008;
  localparam logic [16:0] A_CHI  = 17'h0000C;
  localparam logic [16:0] A_KLO  = 17'h10020;
  localparam logic [16:0] A_KHI  = 17'h10024;
  localparam logic [16:0] A_CTL  = 17'h1002C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [16:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int ncyc   = 0;
  bit done   = 1'b0;

  freerun_cmp_timer dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

  // Expected count from the bench's own tally of edges since reset
  function automatic longint exp_count(int edges);
    return longint'(edges / 3);
  endfunction

  function automatic bit known_addr(logic [16:0] a);
    return a == A_CLO || a == A_CHI || a == A_KLO || a == A_KHI || a == A_CTL;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
    end
  endtask

  // Called at a negedge; returns at the next negedge after the write edge
  task automatic wr(logic [16:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [16:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  // Arm the frame at cmp and follow the status each cycle
  task automatic run_match(longint cmp, bit mask, int cycles);
    logic [31:0] r;
    bit expst;
    wr(A_CTL, 32'h0);
    wr(A_KHI, 32'(cmp >> 32));
    wr(A_KLO, 32'(cmp));
    wr(A_CTL, {30'h0, mask, 1'b1});
    expst = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      if (exp_count(ncyc - 1) >= cmp) expst = 1'b1;
      chk("R6 irq follows status and mask", {31'h0, irq}, {31'h0, expst & ~mask});
      rd(A_CTL, r);
      chk("R5 status set on reaching compare", r, {29'h0, expst, mask, 1'b1});
      @(negedge clk);
    end
    wr(A_CTL, 32'h0);
    chk("R7 irq low after enable cleared", {31'h0, irq}, 32'h0);
    rd(A_CTL, r);
    chk("R7 status cleared with enable", r, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    longint now;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9: reset values before release
    rd(A_KLO, r); chk("R9 compare low reset", r, 32'hFFFF_FFFF);
    rd(A_KHI, r); chk("R9 compare high reset", r, 32'h000F_FFFF);
    rd(A_CTL, r); chk("R9 control reset", r, 32'h0);
    rd(A_CLO, r); chk("R1 count zero in reset", r, 32'h0);
    chk("R9 irq low in reset", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: count rate sampled at scattered times
    for (int i = 0; i < 8; i++) begin
      repeat ($urandom % 7) @(negedge clk);
      rd(A_CLO, r); chk("R1 count low tracks clock/3", r, 32'(exp_count(ncyc)));
      rd(A_CHI, r); chk("R2 count high word", r, 32'h0);
    end

    // R2: writes to count words ignored
    wr(A_CLO, 32'h1234_5678);
    wr(A_CHI, 32'hFFFF_FFFF);
    rd(A_CLO, r); chk("R2 count low unaffected by write", r, 32'(exp_count(ncyc)));
    rd(A_CHI, r); chk("R2 count high unaffected by write", r, 32'h0);

    // R9: unmapped offsets read zero
    for (int i = 0; i < 10; i++) begin
      logic [16:0] a;
      a = 17'($urandom);
      if (!known_addr(a)) begin
        rd(a, r); chk("R9 unmapped read zero", r, 32'h0);
      end
    end
    rd(17'h10028, r); chk("R9 gap in frame reads zero", r, 32'h0);

    // R3: high compare keeps bits [19:0] only
    wr(A_KHI, 32'hFFF0_0001);
    rd(A_KHI, r); chk("R3 compare high masked", r, 32'h0000_0001);
    wr(A_KLO, 32'hA5A5_0F0F);
    rd(A_KLO, r); chk("R3 compare low read back", r, 32'hA5A5_0F0F);

    // R3: high compare word nonzero keeps the match away
    wr(A_KLO, 32'h0);
    wr(A_CTL, 32'h1);
    repeat (20) @(negedge clk);
    rd(A_CTL, r); chk("R3 no match with high compare set", r, 32'h1);
    wr(A_CTL, 32'h0);

    // R4: status bit not writable, upper bits read zero
    wr(A_CTL, 32'hFFFF_FFF4);
    rd(A_CTL, r); chk("R4 status bit read-only", r, 32'h0);
    wr(A_CTL, 32'hFFFF_FFFE);
    rd(A_CTL, r); chk("R4 mask alone, upper bits zero", r, 32'h2);
    wr(A_CTL, 32'h0);

    // R5: compare already behind the count matches at once
    run_match(0, 1'b0, 4);
    // R5/R6: directed ahead of the count, unmasked and masked
    now = exp_count(ncyc);
    run_match(now + 6, 1'b0, 30);
    now = exp_count(ncyc);
    run_match(now + 5, 1'b1, 30);

    // R6: unmasking a set status raises the interrupt
    wr(A_KHI, 32'h0); wr(A_KLO, 32'h0);
    wr(A_CTL, 32'h3);
    chk("R6 masked irq low", {31'h0, irq}, 32'h0);
    rd(A_CTL, r); chk("R6 status set under mask", r, 32'h7);
    wr(A_CTL, 32'h1);
    chk("R6 irq after unmask", {31'h0, irq}, 32'h1);

    // R5: raising compare does not clear a set status
    wr(A_KHI, 32'h000F_FFFF);
    repeat (4) @(negedge clk);
    rd(A_CTL, r); chk("R5 status sticky after compare raised", r, 32'h5);
    wr(A_CTL, 32'h0);
    chk("R7 irq drops on enable clear", {31'h0, irq}, 32'h0);

    // R8: compare write takes effect one edge late
    wr(A_KHI, 32'h0); wr(A_KLO, 32'hFFFF_FFFF);
    wr(A_CTL, 32'h1);
    wr(A_KLO, 32'h0);
    rd(A_CTL, r); chk("R8 old compare used on write edge", r, 32'h1);
    @(negedge clk);
    rd(A_CTL, r); chk("R8 new compare used next edge", r, 32'h5);
    wr(A_CTL, 32'h0);

    // Random arming offsets and masks
    for (int i = 0; i < 30; i++) begin
      int delta;
      bit m;
      delta = int'($urandom % 12);
      m = 1'($urandom);
      now = exp_count(ncyc);
      run_match(now + longint'(delta), m, 3 * delta + 12);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule